// File: doc/BRIEF.md
# Half-Pel Interpolating SAD Engine

This block scores how well a candidate reference block matches a current block of 8-bit pixels. Its score is the sum of absolute differences (SAD). The reference can be used as it is, or it can be resampled at a half-pixel offset before the comparison. The offset can be to the right, downward, or diagonal. A motion search controller loads the mode, the width (8 or 16 pixels) and, for wide blocks, the row count. It pulses `start_i` and then streams one row per beat. Each beat carries a current row and a reference row. The reference row has one extra pixel on the right, so the rightmost lane can be averaged with its neighbour.

In the vertical and diagonal modes the engine keeps the previous reference row internally, so each reference row is delivered only once. The first beat of these modes only loads that register. Its current-row data is not used, so a block of h rows takes h+1 beats. Diagonal resampling is normally exact. A faster approximation can be chosen, but only when bit-exactness is not demanded. When the programmed row count has been taken, `done_o` pulses and `sad_o` holds the total.

Top module: `sad_halfpel_engine`

## Requirements
- R1: Full mode (`mode_i`=0): each row adds the sum over its lanes of |cur[k] − ref[k]|. Pixel k of a row sits at bits [8k+7:8k], and lane 0 is leftmost. Each absolute difference is the OR of the two saturating unsigned differences.
- R2: Horizontal mode (`mode_i`=1): the reference pixel for lane k is (ref[k] + ref[k+1] + 1) >> 1.
- R3: Vertical mode (`mode_i`=2): the first accepted beat only stores its reference row and adds nothing. After that, lane k compares against (prev[k] + ref[k] + 1) >> 1, where prev is the reference row of the preceding beat.
- R4: Diagonal mode (`mode_i`=3) is exact when `approx_i` is 0 or `bitexact_i` is 1. Lane k then uses (prev[k] + prev[k+1] + ref[k] + ref[k+1] + 2) >> 2, with no loss in the intermediate sum.
- R5: Diagonal mode with `approx_i`=1 and `bitexact_i`=0 is the approximate path. It takes u = avg(prev[k], prev[k+1]) and l = avg(ref[k], ref[k+1]). It lowers l by 1, saturating at 0, and then outputs avg(u, l), where avg(a,b) = (a+b+1)>>1.
- R6: With `wide_i`=1 all 16 lanes contribute, summed as two 8-lane halves. With `wide_i`=0 only lanes 0..7 contribute. Current bytes 8..15 and reference bytes 9..16 have no effect.
- R7: A narrow block always takes 8 rows. A wide block takes `rows_i` rows, and a value of 0 is treated as 1.
- R8: `sad_o` is the running total modulo 65536.
- R9: `start_i` while idle clears the total, latches the configuration and makes `busy_o` high. `start_i` while busy is ignored.
- R10: `done_o` is high for exactly one cycle, in the cycle after the edge that accepts the final row. `sad_o` then holds its value until the next accepted start.
- R11: A beat is accepted only on an edge where `row_valid_i` and `busy_o` are both high. Rows offered while idle, or without valid, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (taken only while idle) |
| mode_i | input | 2 | 0 full, 1 horizontal half, 2 vertical half, 3 diagonal half |
| wide_i | input | 1 | 1 selects 16-pixel rows, 0 selects 8 |
| rows_i | input | 5 | Row count of a wide block |
| approx_i | input | 1 | Request the approximate diagonal average |
| bitexact_i | input | 1 | Forbid the approximate diagonal average |
| row_valid_i | input | 1 | A row is present on the data inputs |
| cur_row_i | input | 128 | Current row, 16 pixels |
| ref_row_i | input | 136 | Reference row, 17 pixels |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sad_o | output | 16 | Accumulated SAD |

## Verification
A wrong row counter or priming flag shows up as a total that is off by a whole row's SAD. It also moves the `done_o` pulse one beat early or late, and that is visible on the very cycle the pulse is expected. A corrupt previous-row register or a wrong rounding choice changes `sad_o` only through the interpolated lanes. Random pixel data makes nearly every row show such an error in the final total. A lost lane mask in narrow mode adds the garbage upper bytes, so the total at `done_o` is visibly too large.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int PIX_W = 8;

  typedef enum logic [1:0] {
    MODE_FULL = 2'd0,
    MODE_HORZ = 2'd1,
    MODE_VERT = 2'd2,
    MODE_DIAG = 2'd3
  } ref_mode_e;

  // rounded-up mean of two pixels
  function automatic logic [PIX_W-1:0] avg2(input logic [PIX_W-1:0] a,
                                            input logic [PIX_W-1:0] b);
    logic [PIX_W:0] s;
    s = {1'b0, a} + {1'b0, b} + (PIX_W+1)'(1);
    return s[PIX_W:1];
  endfunction

  // exact rounded mean of four pixels, two guard bits
  function automatic logic [PIX_W-1:0] avg4(input logic [PIX_W-1:0] a,
                                            input logic [PIX_W-1:0] b,
                                            input logic [PIX_W-1:0] c,
                                            input logic [PIX_W-1:0] d);
    logic [PIX_W+1:0] s;
    s = (PIX_W+2)'(a) + (PIX_W+2)'(b) + (PIX_W+2)'(c) + (PIX_W+2)'(d)
        + (PIX_W+2)'(2);
    return s[PIX_W+1:2];
  endfunction

  // cheap diagonal: pairwise means, lower one biased down, then mean again
  function automatic logic [PIX_W-1:0] avg4_fast(input logic [PIX_W-1:0] up_l,
                                                 input logic [PIX_W-1:0] up_r,
                                                 input logic [PIX_W-1:0] lo_l,
                                                 input logic [PIX_W-1:0] lo_r);
    logic [PIX_W-1:0] u, l;
    u = avg2(up_l, up_r);
    l = avg2(lo_l, lo_r);
    l = (l == '0) ? '0 : l - PIX_W'(1);
    return avg2(u, l);
  endfunction

  // |x - y| as the union of two clamped differences
  function automatic logic [PIX_W-1:0] absdiff(input logic [PIX_W-1:0] x,
                                               input logic [PIX_W-1:0] y);
    logic [PIX_W-1:0] d_xy, d_yx;
    d_xy = (x > y) ? x - y : '0;
    d_yx = (y > x) ? y - x : '0;
    return d_xy | d_yx;
  endfunction
endpackage

// File: rtl/sad_interp.sv
module sad_interp
  import sad_pkg::*;
#(
  parameter int LANES = 16
) (
  input  ref_mode_e                  mode_i,
  input  logic                       fast_i,
  input  logic [(LANES+1)*PIX_W-1:0] prev_i,
  input  logic [(LANES+1)*PIX_W-1:0] ref_i,
  output logic [LANES*PIX_W-1:0]     pred_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PIX_W-1:0] a, b, p, q, pix;
    assign a = ref_i[k*PIX_W +: PIX_W];
    assign b = ref_i[(k+1)*PIX_W +: PIX_W];
    assign p = prev_i[k*PIX_W +: PIX_W];
    assign q = prev_i[(k+1)*PIX_W +: PIX_W];

    always_comb begin
      unique case (mode_i)
        MODE_FULL: pix = a;
        MODE_HORZ: pix = avg2(a, b);
        MODE_VERT: pix = avg2(p, a);
        default:   pix = fast_i ? avg4_fast(p, q, a, b) : avg4(p, q, a, b);
      endcase
    end
    assign pred_o[k*PIX_W +: PIX_W] = pix;

    // R2
    always_comb begin
      if (mode_i == MODE_HORZ)
        hpel_bound_chk: assert (pix >= ((a < b) ? a : b) && pix <= ((a > b) ? a : b));
    end
  end
endmodule

// File: rtl/sad_row_sum.sv
module sad_row_sum
  import sad_pkg::*;
#(
  parameter int LANES = 8,
  parameter int SUM_W = PIX_W + $clog2(LANES)
) (
  input  logic [LANES*PIX_W-1:0] cur_i,
  input  logic [LANES*PIX_W-1:0] pred_i,
  output logic [SUM_W-1:0]       sum_o
);
  logic [PIX_W-1:0] diff [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_diff
    assign diff[k] = absdiff(cur_i[k*PIX_W +: PIX_W], pred_i[k*PIX_W +: PIX_W]);
  end

  always_comb begin
    sum_o = '0;
    for (int k = 0; k < LANES; k++) sum_o = sum_o + SUM_W'(diff[k]);
  end
endmodule

// File: rtl/sad_halfpel_engine.sv
module sad_halfpel_engine
  import sad_pkg::*;
#(
  parameter int LANES       = 16,
  parameter int HALF        = 8,
  parameter int ROW_W       = 5,
  parameter int SAD_W       = 16,
  parameter int NARROW_ROWS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [1:0]                 mode_i,
  input  logic                       wide_i,
  input  logic [ROW_W-1:0]           rows_i,
  input  logic                       approx_i,
  input  logic                       bitexact_i,
  input  logic                       row_valid_i,
  input  logic [LANES*PIX_W-1:0]     cur_row_i,
  input  logic [(LANES+1)*PIX_W-1:0] ref_row_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [SAD_W-1:0]           sad_o
);
  localparam int NHALF  = LANES / HALF;
  localparam int HSUM_W = PIX_W + $clog2(HALF);
  localparam int RSUM_W = HSUM_W + $clog2(NHALF) + 1;
  localparam int NR_W   = $clog2(NARROW_ROWS + 1);
  localparam int CNT_W  = (ROW_W > NR_W) ? ROW_W : NR_W;

  logic                       busy_q, done_q, prime_q, wide_q, fast_q;
  ref_mode_e                  mode_q;
  logic [CNT_W-1:0]           left_q, start_rows;
  logic [SAD_W-1:0]           acc_q;
  logic [(LANES+1)*PIX_W-1:0] prev_q;
  logic [LANES*PIX_W-1:0]     pred;
  logic [HSUM_W-1:0]          half_sum [NHALF];
  logic [RSUM_W-1:0]          row_sum;

  // named events
  logic start_fire, beat_fire, row_take, last_row;
  assign start_fire = start_i && !busy_q;
  assign beat_fire  = row_valid_i && busy_q;
  assign row_take   = beat_fire && !prime_q;
  assign last_row   = row_take && (left_q == CNT_W'(1));

  always_comb begin
    if (!wide_i)            start_rows = CNT_W'(NARROW_ROWS);
    else if (rows_i == '0)  start_rows = CNT_W'(1);
    else                    start_rows = CNT_W'(rows_i);
  end

  sad_interp #(.LANES(LANES)) u_interp (
    .mode_i (mode_q),
    .fast_i (fast_q),
    .prev_i (prev_q),
    .ref_i  (ref_row_i),
    .pred_o (pred)
  );

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    sad_row_sum #(.LANES(HALF), .SUM_W(HSUM_W)) u_sum (
      .cur_i  (cur_row_i[h*HALF*PIX_W +: HALF*PIX_W]),
      .pred_i (pred[h*HALF*PIX_W +: HALF*PIX_W]),
      .sum_o  (half_sum[h])
    );
  end

  always_comb begin
    row_sum = '0;
    for (int h = 0; h < NHALF; h++)
      if (h == 0 || wide_q) row_sum = row_sum + RSUM_W'(half_sum[h]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      prime_q <= 1'b0;
      wide_q  <= 1'b0;
      fast_q  <= 1'b0;
      mode_q  <= MODE_FULL;
      left_q  <= '0;
      acc_q   <= '0;
      prev_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_fire) begin
        busy_q  <= 1'b1;
        acc_q   <= '0;
        left_q  <= start_rows;
        mode_q  <= ref_mode_e'(mode_i);
        wide_q  <= wide_i;
        fast_q  <= approx_i && !bitexact_i;
        prime_q <= (mode_i == MODE_VERT) || (mode_i == MODE_DIAG);
      end else if (beat_fire) begin
        prev_q  <= ref_row_i;
        prime_q <= 1'b0;
        if (row_take) begin
          acc_q  <= acc_q + SAD_W'(row_sum);
          left_q <= left_q - CNT_W'(1);
        end
        if (last_row) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign sad_o  = acc_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(sad_o));
  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> (busy_o && sad_o == '0));
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R3
  prime_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && prime_q) |=> $stable(sad_o));
  // R7
  count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_take |-> (left_q != '0));
endmodule

// File: tb/test_sad_halfpel_engine.sv
`timescale 1ns/1ps
module test_sad_halfpel_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [1:0]   mode_i = '0;
  logic         wide_i = 1'b0;
  logic [4:0]   rows_i = '0;
  logic         approx_i = 1'b0;
  logic         bitexact_i = 1'b0;
  logic         row_valid_i = 1'b0;
  logic [127:0] cur_row_i = '0;
  logic [135:0] ref_row_i = '0;
  logic         busy_o, done_o;
  logic [15:0]  sad_o;

  int n_vec = 0;
  int n_bad = 0;
  bit ended = 1'b0;
  int unsigned lcg = 32'h1234_5678;

  int cur_m [0:31][0:15];
  int ref_m [0:32][0:16];

  always #2.5 clk = ~clk;

  sad_halfpel_engine i_sad_halfpel_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .wide_i(wide_i), .rows_i(rows_i), .approx_i(approx_i),
    .bitexact_i(bitexact_i), .row_valid_i(row_valid_i),
    .cur_row_i(cur_row_i), .ref_row_i(ref_row_i),
    .busy_o(busy_o), .done_o(done_o), .sad_o(sad_o)
  );

  function automatic int rnd8();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return int'(lcg[23:16]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fill_random();
    for (int r = 0; r < 32; r++) for (int k = 0; k < 16; k++) cur_m[r][k] = rnd8();
    for (int r = 0; r < 33; r++) for (int k = 0; k < 17; k++) ref_m[r][k] = rnd8();
  endtask

  task automatic fill_const(input int c, input int f);
    for (int r = 0; r < 32; r++) for (int k = 0; k < 16; k++) cur_m[r][k] = c;
    for (int r = 0; r < 33; r++) for (int k = 0; k < 17; k++) ref_m[r][k] = f;
  endtask

  // predicted reference pixel, restated from the requirements
  function automatic int ref_pix(int mode, bit fast, int row, int k);
    int up, lo, s;
    case (mode)
      0: return ref_m[row][k];
      1: return (ref_m[row][k] + ref_m[row][k+1] + 1) / 2;
      2: return (ref_m[row][k] + ref_m[row+1][k] + 1) / 2;
      default: begin
        if (!fast) begin
          s = ref_m[row][k] + ref_m[row][k+1] + ref_m[row+1][k] + ref_m[row+1][k+1];
          return (s + 2) / 4;
        end
        up = (ref_m[row][k] + ref_m[row][k+1] + 1) / 2;
        lo = (ref_m[row+1][k] + ref_m[row+1][k+1] + 1) / 2;
        lo = (lo > 0) ? lo - 1 : 0;
        return (up + lo + 1) / 2;
      end
    endcase
  endfunction

  function automatic int model(int mode, bit fast, int nrows, int lanes);
    int t = 0;
    for (int r = 0; r < nrows; r++)
      for (int k = 0; k < lanes; k++) begin
        int d = cur_m[r][k] - ref_pix(mode, fast, r, k);
        t += (d < 0) ? -d : d;
      end
    return t % 65536;
  endfunction

  task automatic put_row(input int cr, input int rr);
    for (int k = 0; k < 16; k++)
      cur_row_i[8*k +: 8] = (cr < 0) ? 8'(rnd8()) : 8'(cur_m[cr][k]);
    for (int k = 0; k < 17; k++) ref_row_i[8*k +: 8] = 8'(ref_m[rr][k]);
  endtask

  // one full operation; checks done timing, result and hold
  task automatic run_op(input string req, input int mode, input bit wide,
                        input int rows_prog, input bit approx, input bit bexact,
                        input bit gaps, input bit restart_mid, input bit extra);
    int nrows, beats, prime, exp;
    bit fast;
    nrows = wide ? ((rows_prog == 0) ? 1 : rows_prog) : 8;
    prime = (mode >= 2) ? 1 : 0;
    beats = nrows + prime;
    fast  = approx && !bexact && mode == 3;
    exp   = model(mode, fast, nrows, wide ? 16 : 8);
    @(negedge clk);
    mode_i = 2'(mode); wide_i = wide; rows_i = 5'(rows_prog);
    approx_i = approx; bitexact_i = bexact; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk({req, " busy after start"}, int'(busy_o), 1);
    chk({req, " cleared by start"}, int'(sad_o), 0);
    for (int b = 0; b < beats; b++) begin
      if (gaps) begin
        row_valid_i = 1'b0;
        put_row(-1, 32);
        @(negedge clk);
      end
      put_row((b < prime) ? -1 : b - prime, b);
      row_valid_i = 1'b1;
      if (restart_mid && b == 2) begin
        start_i = 1'b1;
        mode_i = 2'(mode ^ 1);
        wide_i = ~wide;
      end
      @(negedge clk);
      row_valid_i = 1'b0;
      start_i = 1'b0;
      if (b < beats - 1) chk({req, " no early done"}, int'(done_o), 0);
    end
    chk({req, " done pulse"}, int'(done_o), 1);
    chk({req, " sad"}, int'(sad_o), exp);
    @(negedge clk);
    chk({req, " done one cycle (R10)"}, int'(done_o), 0);
    chk({req, " held (R10)"}, int'(sad_o), exp);
    if (extra) begin
      put_row(0, 0);
      row_valid_i = 1'b1;
      @(negedge clk);
      row_valid_i = 1'b0;
      @(negedge clk);
      chk("R11 extra row ignored sad", int'(sad_o), exp);
      chk("R11 extra row no done", int'(done_o), 0);
      chk("R11 extra row stays idle", int'(busy_o), 0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!ended) begin
      ended = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset busy", int'(busy_o), 0);
    chk("R10 reset done", int'(done_o), 0);
    chk("R8 reset sad", int'(sad_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 row offered while idle changes nothing
    fill_random();
    put_row(0, 0); row_valid_i = 1'b1;
    @(negedge clk); row_valid_i = 1'b0;
    chk("R11 idle row ignored", int'(sad_o), 0);

    fill_random(); run_op("R1 full narrow, R6 upper lanes ignored", 0, 0, 0, 0, 0, 0, 0, 1);
    fill_random(); run_op("R2 horizontal", 1, 0, 0, 0, 0, 0, 0, 0);
    fill_random(); run_op("R3 vertical", 2, 0, 0, 0, 0, 0, 0, 0);
    fill_random(); run_op("R4 diagonal exact", 3, 0, 0, 0, 0, 0, 0, 0);
    fill_random(); run_op("R4 approx blocked by bitexact", 3, 0, 0, 1, 1, 0, 0, 0);
    fill_random(); run_op("R5 diagonal approx", 3, 0, 0, 1, 0, 0, 0, 0);
    fill_const(0, 0); run_op("R5 approx saturates at zero", 3, 0, 0, 1, 0, 0, 0, 0);
    fill_random(); run_op("R6 wide full", 0, 1, 5, 0, 0, 0, 0, 0);
    fill_random(); run_op("R6 wide diagonal approx", 3, 1, 3, 1, 0, 0, 0, 0);
    fill_random(); run_op("R7 wide zero rows as one", 1, 1, 0, 0, 0, 0, 0, 0);
    fill_random(); run_op("R7 wide vertical 12 rows", 2, 1, 12, 0, 0, 0, 0, 0);
    fill_const(255, 0); run_op("R8 truncation", 0, 1, 31, 0, 0, 0, 0, 0);
    fill_random(); run_op("R9 start while busy ignored", 2, 0, 0, 0, 0, 0, 1, 0);
    fill_random(); run_op("R11 valid gaps", 3, 1, 4, 0, 0, 1, 0, 1);

    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule